// File: doc/BRIEF.md
# Multithreaded Core Low-Power Sequencer

This block sequences the power states of a cluster of dual-threaded cores (four by default). Each core is in one of four states: running, light sleep (fetch stopped, L1 snooping kept, clocks running), deep sleep (fetch and snooping stopped, clocks off, retention voltage requested) or exiting (deep-sleep wake in progress). For each core the block drives fetch, snoop, clock and retention-voltage enables that follow from its state. It also drives an L2 flush request/acknowledge handshake and a cluster deep-sleep flag. The clock gates, the regulator and the flush engine are outside the block.

A core sleeps in one of two ways. Software can issue a register write that names a source core, a target core and an operation. A core can also sleep on its own instructions: each thread pulses WAIT, and the core drops into deep sleep once both of its threads have waited. How a core went to sleep decides which wake events it accepts. The whole cluster can be put into deep sleep once every core is in light sleep. Waking from any deep state takes a parameterised exit latency.

Top module: `lps_seq`

## Requirements
- R1: After reset every core reports code 0 (run), all fetch, snoop and clock enables are 1, every retention request is 0, and the flush request, cluster deep flag and rejection flag are all 0.
- R2: Per-core outputs follow the 2-bit state code in `core_state[2c+1:2c]`:
  - run (0): fetch, snoop and clock on, retention off.
  - light (1): snoop and clock on only.
  - deep (2): retention on only.
  - exiting (3): clock on only.
- R3: A register write with `cfg_op` 1 (light) or 2 (deep) moves a running target core to that state on the next clock edge. The write may come from any source, including the target itself.
- R4: A register write with `cfg_op` 0 (wake) wakes a target core when `cfg_src` differs from `cfg_tgt`: a light-sleeping core returns to run at the next edge, and a deep-sleeping core goes to exiting. A wake write whose source equals its target has no effect.
- R5: A core put to sleep by register write is woken only by the external trigger `ev_ext` or by another core's wake write. Its interrupt, doorbell, stash and reservation-clear events are ignored.
- R6: Thread t of core c pulses `thr_wait[2c+t]`. A core enters deep sleep only once both threads have waited, either in the same cycle or separately. A single WAIT leaves the core running.
- R7: A core that slept through WAIT leaves deep sleep on any one of its five wake events (external trigger, interrupt, doorbell, stash, reservation clear).
- R8: A core leaving deep sleep reports exiting for exactly EXIT_CYCLES cycles (default 100), then runs. It never passes directly from deep to run.
- R9: A register write with `cfg_op` 3, made while every core is in light sleep, raises `l2_flush_req`. The request is held until `l2_flush_ack`, after which `cluster_deep` is 1 and every core reports deep with deep-sleep outputs.
- R10: A cluster-sleep write made while any core is not in light sleep is rejected: no flush starts, and `clus_err` is set and stays set until reset.
- R11: A qualified wake for any core during cluster deep sleep exits the cluster. All cores report exiting for EXIT_CYCLES cycles, after which the woken core runs and the rest return to light sleep.
- R12: A qualified wake that arrives while the flush handshake is pending is held. On the acknowledge, the cluster goes straight to exiting and skips deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_op | input | 2 | Operation: 0 wake, 1 light, 2 deep, 3 cluster deep |
| cfg_src | input | ID_W | Core issuing the write |
| cfg_tgt | input | ID_W | Core addressed by the write |
| thr_wait | input | 2*NUM_CORES | WAIT pulse per thread, bit 2c+t |
| ev_ext | input | NUM_CORES | External trigger per core |
| ev_irq | input | NUM_CORES | Interrupt per core |
| ev_dbell | input | NUM_CORES | Doorbell per core |
| ev_stash | input | NUM_CORES | L1 data cache stash per core |
| ev_resv | input | NUM_CORES | Snoop-caused reservation clear per core |
| l2_flush_ack | input | 1 | Flush completion acknowledge |
| fetch_en | output | NUM_CORES | Instruction fetch enable |
| snoop_en | output | NUM_CORES | L1 snoop enable |
| clk_en | output | NUM_CORES | Core clock enable |
| ret_req | output | NUM_CORES | Retention voltage request |
| l2_flush_req | output | 1 | L2 flush request |
| cluster_deep | output | 1 | Cluster in deep sleep |
| core_state | output | 2*NUM_CORES | 2-bit state code per core |
| clus_err | output | 1 | Sticky rejected cluster-sleep flag |

## Verification
The hardest state to reach from the ports is a wake that arrives inside the flush window. To get there, the stimulus puts all four cores to sleep by register writes, issues the cluster request, and holds off `l2_flush_ack`. While the request is still raised, it pulses one core's external trigger, then acknowledges and watches for the exiting code with no deep-sleep cycle before it. The split between register-slept and instruction-slept cores is reached by sleeping one core each way and pulsing all five event kinds at both.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        CS_RUN   = 2'd0,
        CS_LIGHT = 2'd1,
        CS_DEEP  = 2'd2,
        CS_EXIT  = 2'd3
    } core_st_e;

    typedef enum logic [1:0] {
        OP_WAKE    = 2'd0,
        OP_LIGHT   = 2'd1,
        OP_DEEP    = 2'd2,
        OP_CLUSTER = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        CL_IDLE  = 2'd0,
        CL_FLUSH = 2'd1,
        CL_DEEP  = 2'd2,
        CL_EXIT  = 2'd3
    } clus_st_e;

endpackage

// File: rtl/lps_core_fsm.sv
module lps_core_fsm
    import lps_pkg::*;
#(
    parameter int EXIT_CYCLES = 100,
    parameter int CNT_W       = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       rel,
    input  logic       reg_light,
    input  logic       reg_deep,
    input  logic       reg_wake,
    input  logic [1:0] wait_p,
    input  logic       ev_ext,
    input  logic       ev_other,
    output core_st_e   st,
    output logic       wake_hit
);

    typedef struct packed {
        core_st_e         st;
        logic             by_reg;
        logic [1:0]       waits;
        logic [CNT_W-1:0] cnt;
    } core_reg_t;

    localparam core_reg_t RST_VAL = '{st: CS_RUN, by_reg: 1'b0, waits: 2'b00, cnt: '0};
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYCLES - 1);

    core_reg_t cur_q, nxt_d;
    logic [1:0] waits_acc;
    logic       asleep;

    assign waits_acc = cur_q.waits | wait_p;
    assign asleep    = (cur_q.st == CS_LIGHT) || (cur_q.st == CS_DEEP);
    // register-slept cores only accept the external trigger or a peer write
    assign wake_hit  = asleep && (reg_wake || ev_ext || (!cur_q.by_reg && ev_other));

    always_comb begin
        nxt_d = cur_q;
        if (rel) begin
            nxt_d.st     = CS_RUN;
            nxt_d.by_reg = 1'b0;
            nxt_d.waits  = 2'b00;
        end else if (!freeze) begin
            case (cur_q.st)
                CS_RUN: begin
                    if (reg_light) begin
                        nxt_d.st     = CS_LIGHT;
                        nxt_d.by_reg = 1'b1;
                        nxt_d.waits  = 2'b00;
                    end else if (reg_deep) begin
                        nxt_d.st     = CS_DEEP;
                        nxt_d.by_reg = 1'b1;
                        nxt_d.waits  = 2'b00;
                    end else if (&waits_acc) begin
                        nxt_d.st     = CS_DEEP;
                        nxt_d.by_reg = 1'b0;
                        nxt_d.waits  = 2'b00;
                    end else begin
                        nxt_d.waits  = waits_acc;
                    end
                end
                CS_LIGHT: begin
                    if (wake_hit) begin
                        nxt_d.st     = CS_RUN;
                        nxt_d.by_reg = 1'b0;
                    end
                end
                CS_DEEP: begin
                    if (wake_hit) begin
                        nxt_d.st     = CS_EXIT;
                        nxt_d.by_reg = 1'b0;
                        nxt_d.cnt    = CNT_LOAD;
                    end
                end
                default: begin
                    if (cur_q.cnt == '0) begin
                        nxt_d.st = CS_RUN;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= RST_VAL;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st = cur_q.st;

endmodule

// File: rtl/lps_cluster_fsm.sv
module lps_cluster_fsm
    import lps_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int EXIT_CYCLES = 100,
    parameter int CNT_W       = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 all_light,
    input  logic [NUM_CORES-1:0] wake_hits,
    input  logic                 flush_ack,
    output clus_st_e             cst,
    output logic [NUM_CORES-1:0] rel,
    output logic                 flush_req,
    output logic                 err
);

    typedef struct packed {
        clus_st_e             st;
        logic [NUM_CORES-1:0] pend;
        logic [CNT_W-1:0]     cnt;
        logic                 err;
    } clus_reg_t;

    localparam clus_reg_t RST_VAL = '{st: CL_IDLE, pend: '0, cnt: '0, err: 1'b0};
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYCLES - 1);

    clus_reg_t cur_q, nxt_d;
    logic [NUM_CORES-1:0] pend_acc;

    assign pend_acc = cur_q.pend | wake_hits;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            CL_IDLE: begin
                if (req) begin
                    if (all_light) begin
                        nxt_d.st   = CL_FLUSH;
                        nxt_d.pend = '0;
                    end else begin
                        nxt_d.err  = 1'b1;
                    end
                end
            end
            CL_FLUSH: begin
                nxt_d.pend = pend_acc;
                if (flush_ack) begin
                    nxt_d.st  = (|pend_acc) ? CL_EXIT : CL_DEEP;
                    nxt_d.cnt = CNT_LOAD;
                end
            end
            CL_DEEP: begin
                if (|wake_hits) begin
                    nxt_d.st   = CL_EXIT;
                    nxt_d.pend = wake_hits;
                    nxt_d.cnt  = CNT_LOAD;
                end
            end
            default: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.st   = CL_IDLE;
                    nxt_d.pend = '0;
                end else begin
                    nxt_d.cnt  = cur_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= RST_VAL;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cst       = cur_q.st;
    assign rel       = (cur_q.st == CL_EXIT && cur_q.cnt == '0) ? cur_q.pend : '0;
    assign flush_req = (cur_q.st == CL_FLUSH);
    assign err       = cur_q.err;

endmodule

// File: rtl/lps_core_out.sv
module lps_core_out
    import lps_pkg::*;
(
    input  core_st_e   st,
    input  clus_st_e   cst,
    output logic       fetch,
    output logic       snoop,
    output logic       clk_on,
    output logic       ret,
    output logic [1:0] code
);

    core_st_e eff;

    always_comb begin
        eff = st;
        if (cst == CL_DEEP) begin
            eff = CS_DEEP;
        end else if (cst == CL_EXIT) begin
            eff = CS_EXIT;
        end
    end

    always_comb begin
        case (eff)
            CS_RUN:   {fetch, snoop, clk_on, ret} = 4'b1110;
            CS_LIGHT: {fetch, snoop, clk_on, ret} = 4'b0110;
            CS_DEEP:  {fetch, snoop, clk_on, ret} = 4'b0001;
            default:  {fetch, snoop, clk_on, ret} = 4'b0010;
        endcase
        code = eff;
    end

endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int EXIT_CYCLES = 100,
    localparam int ID_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_op,
    input  logic [ID_W-1:0]        cfg_src,
    input  logic [ID_W-1:0]        cfg_tgt,
    input  logic [2*NUM_CORES-1:0] thr_wait,
    input  logic [NUM_CORES-1:0]   ev_ext,
    input  logic [NUM_CORES-1:0]   ev_irq,
    input  logic [NUM_CORES-1:0]   ev_dbell,
    input  logic [NUM_CORES-1:0]   ev_stash,
    input  logic [NUM_CORES-1:0]   ev_resv,
    input  logic                   l2_flush_ack,
    output logic [NUM_CORES-1:0]   fetch_en,
    output logic [NUM_CORES-1:0]   snoop_en,
    output logic [NUM_CORES-1:0]   clk_en,
    output logic [NUM_CORES-1:0]   ret_req,
    output logic                   l2_flush_req,
    output logic                   cluster_deep,
    output logic [2*NUM_CORES-1:0] core_state,
    output logic                   clus_err
);

    localparam int CNT_W = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;

    clus_st_e             cst;
    core_st_e             st_v [NUM_CORES];
    logic [NUM_CORES-1:0] light_v;
    logic [NUM_CORES-1:0] hits_v;
    logic [NUM_CORES-1:0] rel_v;
    logic                 freeze;
    logic                 clus_req;

    assign freeze   = (cst != CL_IDLE);
    assign clus_req = cfg_we && (cfg_op == OP_CLUSTER);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic sel, r_light, r_deep, r_wake;

        assign sel     = cfg_we && (cfg_tgt == ID_W'(c));
        assign r_light = sel && (cfg_op == OP_LIGHT);
        assign r_deep  = sel && (cfg_op == OP_DEEP);
        assign r_wake  = sel && (cfg_op == OP_WAKE) && (cfg_src != ID_W'(c));

        lps_core_fsm #(
            .EXIT_CYCLES (EXIT_CYCLES),
            .CNT_W       (CNT_W)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .freeze    (freeze),
            .rel       (rel_v[c]),
            .reg_light (r_light),
            .reg_deep  (r_deep),
            .reg_wake  (r_wake),
            .wait_p    (thr_wait[2*c +: 2]),
            .ev_ext    (ev_ext[c]),
            .ev_other  (ev_irq[c] | ev_dbell[c] | ev_stash[c] | ev_resv[c]),
            .st        (st_v[c]),
            .wake_hit  (hits_v[c])
        );

        assign light_v[c] = (st_v[c] == CS_LIGHT);

        lps_core_out u_out (
            .st     (st_v[c]),
            .cst    (cst),
            .fetch  (fetch_en[c]),
            .snoop  (snoop_en[c]),
            .clk_on (clk_en[c]),
            .ret    (ret_req[c]),
            .code   (core_state[2*c +: 2])
        );
    end

    lps_cluster_fsm #(
        .NUM_CORES   (NUM_CORES),
        .EXIT_CYCLES (EXIT_CYCLES),
        .CNT_W       (CNT_W)
    ) u_clus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (clus_req),
        .all_light (&light_v),
        .wake_hits (hits_v),
        .flush_ack (l2_flush_ack),
        .cst       (cst),
        .rel       (rel_v),
        .flush_req (l2_flush_req),
        .err       (clus_err)
    );

    assign cluster_deep = (cst == CL_DEEP);

endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CORES-1:0]   fetch_en,
    input logic [NUM_CORES-1:0]   snoop_en,
    input logic [NUM_CORES-1:0]   clk_en,
    input logic [NUM_CORES-1:0]   ret_req,
    input logic                   l2_flush_req,
    input logic                   l2_flush_ack,
    input logic                   cluster_deep,
    input logic [2*NUM_CORES-1:0] core_state,
    input logic                   clus_err
);

    logic all_lt, all_dp;

    always_comb begin
        all_lt = 1'b1;
        all_dp = 1'b1;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core_state[2*c +: 2] != 2'd1) all_lt = 1'b0;
            if (core_state[2*c +: 2] != 2'd2) all_dp = 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        a_r2_light_outputs: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[2*c +: 2] == 2'd1) |->
                (!fetch_en[c] && snoop_en[c] && clk_en[c] && !ret_req[c]));

        a_r2_deep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[2*c +: 2] == 2'd2) |->
                (!fetch_en[c] && !snoop_en[c] && !clk_en[c] && ret_req[c]));

        a_r8_no_direct_wake: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[2*c +: 2] == 2'd2) |=>
                (core_state[2*c +: 2] == 2'd2 || core_state[2*c +: 2] == 2'd3));
    end

    a_r9_deep_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cluster_deep) |-> $past(l2_flush_req && l2_flush_ack));

    a_r9_flush_needs_light: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l2_flush_req) |-> $past(all_lt));

    a_r9_cluster_all_deep: assert property (@(posedge clk) disable iff (!rst_n)
        cluster_deep |-> all_dp);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        clus_err |=> clus_err);

endmodule

bind lps_seq lps_seq_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_en     (fetch_en),
    .snoop_en     (snoop_en),
    .clk_en       (clk_en),
    .ret_req      (ret_req),
    .l2_flush_req (l2_flush_req),
    .l2_flush_ack (l2_flush_ack),
    .cluster_deep (cluster_deep),
    .core_state   (core_state),
    .clus_err     (clus_err)
);

// File: tb/lps_seq_test.sv
module lps_seq_test;

    localparam int N    = 4;
    localparam int EXIT = 100;

    logic         clk, rst_n;
    logic         cfg_we;
    logic [1:0]   cfg_op, cfg_src, cfg_tgt;
    logic [7:0]   thr_wait;
    logic [3:0]   ev_ext, ev_irq, ev_dbell, ev_stash, ev_resv;
    logic         l2_flush_ack;
    logic [3:0]   fetch_en, snoop_en, clk_en, ret_req;
    logic         l2_flush_req, cluster_deep, clus_err;
    logic [7:0]   core_state;

    int checks = 0;
    int errors = 0;

    lps_seq #(.NUM_CORES(N), .EXIT_CYCLES(EXIT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_src(cfg_src), .cfg_tgt(cfg_tgt), .thr_wait(thr_wait),
        .ev_ext(ev_ext), .ev_irq(ev_irq), .ev_dbell(ev_dbell),
        .ev_stash(ev_stash), .ev_resv(ev_resv), .l2_flush_ack(l2_flush_ack),
        .fetch_en(fetch_en), .snoop_en(snoop_en), .clk_en(clk_en),
        .ret_req(ret_req), .l2_flush_req(l2_flush_req),
        .cluster_deep(cluster_deep), .core_state(core_state), .clus_err(clus_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {op[7:6], src[5:4], tgt[3:2], expected code[1:0]}
    localparam logic [7:0] VEC [10] = '{
        8'b01_00_01_01, 8'b00_01_01_01, 8'b00_00_01_00, 8'b10_10_11_10,
        8'b00_11_11_10, 8'b01_01_01_01, 8'b01_01_00_01, 8'b00_10_00_00,
        8'b01_00_00_01, 8'b00_10_01_00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code(input int c);
        return core_state[2*c +: 2];
    endfunction

    task automatic reg_op(input logic [1:0] op, input logic [1:0] src, input logic [1:0] tgt);
        cfg_we = 1'b1; cfg_op = op; cfg_src = src; cfg_tgt = tgt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int kind, input int c);
        case (kind)
            0: ev_ext[c]   = 1'b1;
            1: ev_irq[c]   = 1'b1;
            2: ev_dbell[c] = 1'b1;
            3: ev_stash[c] = 1'b1;
            default: ev_resv[c] = 1'b1;
        endcase
        @(negedge clk);
        ev_ext = '0; ev_irq = '0; ev_dbell = '0; ev_stash = '0; ev_resv = '0;
    endtask

    task automatic wait_core_exit(input int c, input string tag);
        chk({tag, " exiting at start"}, 32'(code(c)), 32'd3);
        chk({tag, " exit outputs"}, {fetch_en[c], snoop_en[c], clk_en[c], ret_req[c]}, 4'b0010);
        repeat (EXIT - 1) @(negedge clk);
        chk({tag, " exiting at last cycle"}, 32'(code(c)), 32'd3);
        @(negedge clk);
        chk({tag, " run after exit"}, 32'(code(c)), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_op = '0; cfg_src = '0; cfg_tgt = '0;
        thr_wait = '0; ev_ext = '0; ev_irq = '0; ev_dbell = '0; ev_stash = '0;
        ev_resv = '0; l2_flush_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 core_state", core_state, 8'h00);
        chk("R1 enables", {fetch_en, snoop_en, clk_en}, 12'hFFF);
        chk("R1 retention", ret_req, 4'h0);
        chk("R1 cluster outputs", {l2_flush_req, cluster_deep, clus_err}, 3'b000);

        // R3/R4 register operation table
        for (int i = 0; i < 10; i++) begin
            reg_op(VEC[i][7:6], VEC[i][5:4], VEC[i][3:2]);
            chk((VEC[i][7:6] == 2'd0) ? "R4 wake write" : "R3 sleep write",
                32'(code(int'(VEC[i][3:2]))), 32'(VEC[i][1:0]));
        end

        // R2 outputs: c0 light, c1 run, c2 run, c3 deep
        chk("R2 fetch", fetch_en, 4'b0110);
        chk("R2 snoop", snoop_en, 4'b0111);
        chk("R2 clock", clk_en, 4'b0111);
        chk("R2 retention", ret_req, 4'b1000);

        // R5 register-slept deep core ignores internal events
        for (int k = 1; k < 5; k++) begin
            pulse(k, 3);
            chk("R5 deep core ignores event", 32'(code(3)), 32'd2);
        end
        pulse(0, 3);
        wait_core_exit(3, "R8 register deep");

        // R5 register-slept light core
        pulse(1, 0);
        chk("R5 light core ignores interrupt", 32'(code(0)), 32'd1);
        pulse(0, 0);
        chk("R5 external trigger wakes light core", 32'(code(0)), 32'd0);

        // R6 WAIT on separate threads
        thr_wait[4] = 1'b1; @(negedge clk); thr_wait = '0;
        chk("R6 single wait keeps run", 32'(code(2)), 32'd0);
        thr_wait[5] = 1'b1; @(negedge clk); thr_wait = '0;
        chk("R6 second wait enters deep", 32'(code(2)), 32'd2);
        pulse(1, 2);
        wait_core_exit(2, "R7 interrupt");

        // R7 every event kind, both threads in the same cycle
        for (int k = 0; k < 5; k++) begin
            thr_wait[5:4] = 2'b11; @(negedge clk); thr_wait = '0;
            chk("R6 joint wait enters deep", 32'(code(2)), 32'd2);
            pulse(k, 2);
            wait_core_exit(2, "R7 event kind");
        end

        // R10 rejected cluster request
        reg_op(2'd3, 2'd0, 2'd0);
        chk("R10 no flush on reject", {l2_flush_req, cluster_deep}, 2'b00);
        chk("R10 error set", 32'(clus_err), 32'd1);
        @(negedge clk);
        chk("R10 error sticky", 32'(clus_err), 32'd1);

        // R9 cluster deep sleep
        reg_op(2'd1, 2'd0, 2'd1);
        reg_op(2'd1, 2'd0, 2'd2);
        reg_op(2'd1, 2'd0, 2'd3);
        reg_op(2'd1, 2'd0, 2'd0);
        chk("R9 all light", core_state, 8'h55);
        reg_op(2'd3, 2'd1, 2'd0);
        chk("R9 flush requested", {l2_flush_req, cluster_deep}, 2'b10);
        @(negedge clk);
        chk("R9 flush held", {l2_flush_req, cluster_deep}, 2'b10);
        l2_flush_ack = 1'b1; @(negedge clk); l2_flush_ack = 1'b0;
        chk("R9 cluster deep", {l2_flush_req, cluster_deep}, 2'b01);
        chk("R9 all deep codes", core_state, 8'hAA);
        chk("R9 deep outputs", {fetch_en, snoop_en, clk_en, ret_req}, 16'h000F);

        // R11 wake out of cluster deep
        pulse(0, 1);
        chk("R11 cluster exiting", core_state, 8'hFF);
        chk("R11 cluster flag cleared", 32'(cluster_deep), 32'd0);
        repeat (EXIT - 1) @(negedge clk);
        chk("R11 still exiting", core_state, 8'hFF);
        @(negedge clk);
        chk("R11 woken core runs", core_state, 8'h51);

        // R12 wake held during the flush window
        reg_op(2'd1, 2'd0, 2'd1);
        reg_op(2'd3, 2'd0, 2'd0);
        chk("R12 flush requested", 32'(l2_flush_req), 32'd1);
        pulse(0, 2);
        chk("R12 flush still pending", {l2_flush_req, 6'(code(2))}, 7'b1000001);
        l2_flush_ack = 1'b1; @(negedge clk); l2_flush_ack = 1'b0;
        chk("R12 straight to exit", {cluster_deep, core_state}, 9'h0FF);
        repeat (EXIT - 1) @(negedge clk);
        chk("R12 still exiting", core_state, 8'hFF);
        @(negedge clk);
        chk("R12 held wake delivered", core_state, 8'h45);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule